// File: doc/BRIEF.md
# Pipelined All-One-Polynomial Field Multiplier

This block multiplies two elements of GF(2^M) in polynomial basis, where the field is built on the all-one polynomial 1 + x + x^2 + ... + x^M. That polynomial is taken to be irreducible, and the block does not check it. Each operand is widened to M+1 bits by adding a zero coefficient for x^M. In that wider ring x^(M+1) = 1, so a multiplication by x is a plain one-position rotation.

The product is formed in a square array of (M+1) x (M+1) identical cells. Each cell has one AND gate, one XOR gate and small registers. Row r of the array takes operand A's coefficient r and ANDs it with operand B rotated by r positions. The row XORs that term into a running sum and passes the A vector, the rotated B vector and the sum down to the next row. A final row of M XOR gates folds the x^M coefficient back into the lower bits, because x^M equals the sum of all lower powers.

A new operand pair can be presented on every clock. Each product leaves with its own valid flag after a fixed latency. Optional input and output register stages can be selected by parameter, and the latency follows from that choice.

Top module: `gf_aop_mult`

## Requirements
- R1: When `valid_out` is high, `prod_out` is A*B reduced modulo 1+x+...+x^M, where bit k of every operand and of the result is the coefficient of x^k.
- R2: `valid_out` is `valid_in` delayed by exactly LATENCY = M+1+IN_STAGE+OUT_STAGE clocks. The default build (M=4, both stages registered) gives 7. The product for that pair appears on the same clock.
- R3: A new pair is accepted on every clock with `valid_in` high. Products leave one per clock in the order the pairs entered, and no `valid_out` occurs without a matching input.
- R4: While the synchronous active-high `rst` is high, `valid_out` and `prod_out` are 0 on the clock after it is sampled. Pairs that were in flight at reset never emerge.
- R5: Multiplying by the element 1 (value 1, only bit 0 set) returns the other operand unchanged, in either operand position.
- R6: A zero operand in either position gives a zero product.
- R7: Clocks with `valid_in` low put no result out and do not disturb neighbouring products, whatever is on the operand inputs during those clocks.
- R8: Powers of x wrap through x^(M+1) = 1 and x^M = 1+x+...+x^(M-1). For M=4: x^3*x^2 = 1 (0x1), x^3*x^3 = x (0x2), and x^3*x = 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operand pair present this clock |
| a_in | input | M | Operand A, bit k = coefficient of x^k |
| b_in | input | M | Operand B, bit k = coefficient of x^k |
| valid_out | output | 1 | Product present this clock |
| prod_out | output | M | Reduced product A*B |

## Verification
The cell assertions assume that every row sees A, rotated B and the partial sum that arrived together one clock earlier. Each row must also receive the A coefficient that matches its own index. The occupancy assertions assume that reset has emptied the pipeline before the first `valid_in` is counted. The stimulus therefore holds `rst` for several clocks before it drives any pair. It changes inputs only midway between rising edges and drives arbitrary operands while `valid_in` is low. A reset in mid-stream throws away the expected results still pending, so the outputs are never compared against pairs that the reset discarded.

// File: rtl/gf_aop_pkg.sv
package gf_aop_pkg;

   // Selects whether an edge stage of the multiplier is a register or a wire.
   typedef enum logic {
      STAGE_WIRE = 1'b0,
      STAGE_FLOP = 1'b1
   } stage_e;

   // Clocks from the operand port to the product port.
   function automatic int unsigned aop_latency(int unsigned m, stage_e in_s, stage_e out_s);
      int unsigned lat;
      lat = m + 1;
      if (in_s == STAGE_FLOP) lat = lat + 1;
      if (out_s == STAGE_FLOP) lat = lat + 1;
      return lat;
   endfunction

endpackage

// File: rtl/gf_aop_cell.sv
module gf_aop_cell (
   input  logic clk,
   input  logic rst,
   input  logic a_sel,
   input  logic a_in,
   input  logic b_in,
   input  logic s_in,
   output logic a_out,
   output logic b_out,
   output logic s_out
);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_out <= 1'b0;
         b_out <= 1'b0;
         s_out <= 1'b0;
      end else begin
         a_out <= a_in;
         b_out <= b_in;
         s_out <= s_in ^ (a_sel & b_in);
      end
   end

   // R1: a row whose A coefficient is zero must pass the partial sum unchanged.
   p_hold_sum_r1 : assert property (@(posedge clk) disable iff (rst)
      !a_sel |=> s_out == $past(s_in));

   // R1: a row whose A coefficient is one adds the rotated B bit.
   p_add_term_r1 : assert property (@(posedge clk) disable iff (rst)
      a_sel |=> s_out == ($past(s_in) ^ $past(b_in)));

endmodule

// File: rtl/gf_aop_array.sv
module gf_aop_array #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] a_vec,
   input  logic [N-1:0] b_vec,
   output logic [N-1:0] c_vec
);

   logic [N-1:0] a_w [N];
   logic [N-1:0] b_w [N];
   logic [N-1:0] s_w [N+1];
   logic [N-1:0] bq  [N-1];
   logic [N-1:0] a_tail_unused;
   logic [N-1:0] b_tail_unused;

   assign a_w[0] = a_vec;
   assign b_w[0] = b_vec;
   assign s_w[0] = '0;
   assign c_vec  = s_w[N];

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (r < N - 1) begin : g_inner
            gf_aop_cell u_cell (
               .clk   (clk),
               .rst   (rst),
               .a_sel (a_w[r][r]),
               .a_in  (a_w[r][j]),
               .b_in  (b_w[r][j]),
               .s_in  (s_w[r][j]),
               .a_out (a_w[r+1][j]),
               .b_out (bq[r][j]),
               .s_out (s_w[r+1][j])
            );
         end else begin : g_last
            gf_aop_cell u_cell (
               .clk   (clk),
               .rst   (rst),
               .a_sel (a_w[r][r]),
               .a_in  (a_w[r][j]),
               .b_in  (b_w[r][j]),
               .s_in  (s_w[r][j]),
               .a_out (a_tail_unused[j]),
               .b_out (b_tail_unused[j]),
               .s_out (s_w[N][j])
            );
         end
      end
      // Multiplying by x is a one-place left rotation because x^N = 1.
      if (r < N - 1) begin : g_rot
         assign b_w[r+1] = {bq[r][N-2:0], bq[r][N-1]};
      end
   end

endmodule

// File: rtl/gf_aop_reduce.sv
module gf_aop_reduce
   import gf_aop_pkg::*;
#(
   parameter int unsigned M         = 4,
   parameter stage_e      OUT_STAGE = STAGE_FLOP
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [M:0]   c_vec,
   output logic [M-1:0] p_vec
);

   logic [M-1:0] folded;

   // x^M equals the sum of all lower powers, so its coefficient folds into every bit.
   assign folded = c_vec[M-1:0] ^ {M{c_vec[M]}};

   if (OUT_STAGE == STAGE_FLOP) begin : g_flop
      always_ff @(posedge clk) begin
         if (rst) p_vec <= '0;
         else     p_vec <= folded;
      end
   end else begin : g_wire
      logic side_unused;
      assign side_unused = clk ^ rst;
      assign p_vec = folded;
   end

endmodule

// File: rtl/gf_aop_mult.sv
module gf_aop_mult
   import gf_aop_pkg::*;
#(
   parameter int unsigned M         = 4,
   parameter stage_e      IN_STAGE  = STAGE_FLOP,
   parameter stage_e      OUT_STAGE = STAGE_FLOP
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         valid_in,
   input  logic [M-1:0] a_in,
   input  logic [M-1:0] b_in,
   output logic         valid_out,
   output logic [M-1:0] prod_out
);

   localparam int unsigned N   = M + 1;
   localparam int unsigned LAT = aop_latency(M, IN_STAGE, OUT_STAGE);
   localparam int unsigned CW  = $clog2(LAT + 2);

   if (M < 2) begin : g_bad_m
      $error("gf_aop_mult: M must be at least 2");
   end

   logic [N-1:0] a_ext, b_ext, a_arr, b_arr, c_full;
   logic [LAT-1:0] vld_q;

   assign a_ext = {1'b0, a_in};
   assign b_ext = {1'b0, b_in};

   if (IN_STAGE == STAGE_FLOP) begin : g_in_flop
      always_ff @(posedge clk) begin
         if (rst) begin
            a_arr <= '0;
            b_arr <= '0;
         end else begin
            a_arr <= a_ext;
            b_arr <= b_ext;
         end
      end
   end else begin : g_in_wire
      assign a_arr = a_ext;
      assign b_arr = b_ext;
   end

   gf_aop_array #(.N(N)) u_arr (
      .clk   (clk),
      .rst   (rst),
      .a_vec (a_arr),
      .b_vec (b_arr),
      .c_vec (c_full)
   );

   gf_aop_reduce #(.M(M), .OUT_STAGE(OUT_STAGE)) u_red (
      .clk   (clk),
      .rst   (rst),
      .c_vec (c_full),
      .p_vec (prod_out)
   );

   always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else     vld_q <= {vld_q[LAT-2:0], valid_in};
   end
   assign valid_out = vld_q[LAT-1];

   // Occupancy counter for the checks below: pairs accepted minus products emitted.
   logic [CW-1:0] inflight_q;
   always_ff @(posedge clk) begin
      if (rst) inflight_q <= '0;
      else begin
         case ({valid_in, valid_out})
            2'b10:   inflight_q <= inflight_q + CW'(1);
            2'b01:   inflight_q <= inflight_q - CW'(1);
            default: inflight_q <= inflight_q;
         endcase
      end
   end

   // R2: the pipeline never holds more pairs than its latency.
   p_inflight_cap_r2 : assert property (@(posedge clk) disable iff (rst)
      inflight_q <= CW'(LAT));

   // R3: no product appears without a pair that was accepted earlier.
   p_no_orphan_r3 : assert property (@(posedge clk) disable iff (rst)
      valid_out |-> inflight_q != '0);

   // R4: reset empties the outputs on the next clock.
   p_reset_clear_r4 : assert property (@(posedge clk)
      rst |=> (!valid_out && prod_out == '0));

endmodule

// File: tb/sim_gf_aop_mult.sv
`timescale 1ns/1ps
module sim_gf_aop_mult;
   import gf_aop_pkg::*;

   localparam int unsigned M   = 4;
   localparam int unsigned LAT = M + 3;

   typedef struct {
      logic [M-1:0] exp;
      int unsigned  cyc;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         valid_in = 1'b0;
   logic [M-1:0] a_in = '0;
   logic [M-1:0] b_in = '0;
   logic         valid_out;
   logic [M-1:0] prod_out;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   int unsigned cyc = 0;
   exp_t sb_q[$];

   gf_aop_mult #(.M(M), .IN_STAGE(STAGE_FLOP), .OUT_STAGE(STAGE_FLOP)) u0 (
      .clk(clk), .rst(rst), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
      .valid_out(valid_out), .prod_out(prod_out)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Reference: shift-and-add, doubling by x with x^M replaced by all lower powers.
   function automatic logic [M-1:0] gf_ref(logic [M-1:0] a, logic [M-1:0] b);
      logic [M-1:0] p;
      logic [M-1:0] t;
      logic carry;
      p = '0;
      t = a;
      for (int i = 0; i < M; i++) begin
         if (b[i]) p = p ^ t;
         carry = t[M-1];
         t = t << 1;
         if (carry) t = t ^ {M{1'b1}};
      end
      return p;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic issue_exp(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] e, string tag);
      exp_t it;
      @(negedge clk);
      valid_in = 1'b1;
      a_in = a;
      b_in = b;
      it.exp = e;
      it.cyc = cyc;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic issue(logic [M-1:0] a, logic [M-1:0] b, string tag);
      issue_exp(a, b, gf_ref(a, b), tag);
   endtask

   task automatic bubble();
      @(negedge clk);
      valid_in = 1'b0;
      a_in = M'($urandom);
      b_in = M'($urandom);
   endtask

   // Monitor: compares each emitted product against the head of the scoreboard.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (!rst && valid_out) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R3", "valid_out with no pending pair", 1, 0);
            end else begin
               exp_t it;
               it = sb_q.pop_front();
               check(prod_out == it.exp, it.tag, "product", int'(prod_out), int'(it.exp));
               check(cyc - it.cyc == LAT, "R2", "latency", int'(cyc - it.cyc), int'(LAT));
            end
         end
      end
   end

   initial begin
      #(64'd20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R4: outputs cleared under reset
      repeat (3) @(posedge clk);
      #5;
      check(valid_out == 1'b0, "R4", "valid_out in reset", int'(valid_out), 0);
      check(prod_out == '0, "R4", "prod_out in reset", int'(prod_out), 0);
      @(negedge clk);
      rst = 1'b0;

      // R1 and R3: every operand pair, back to back
      for (int a = 0; a < (1 << M); a++)
         for (int b = 0; b < (1 << M); b++)
            issue(M'(a), M'(b), "R1");

      // R5: identity in both positions
      for (int v = 0; v < (1 << M); v++) begin
         issue_exp(M'(1), M'(v), M'(v), "R5");
         issue_exp(M'(v), M'(1), M'(v), "R5");
      end

      // R6: zero in both positions
      for (int v = 0; v < (1 << M); v++) begin
         issue_exp('0, M'(v), '0, "R6");
         issue_exp(M'(v), '0, '0, "R6");
      end

      // R8: wrap-around of powers of x (M=4)
      issue_exp(4'h8, 4'h4, 4'h1, "R8");
      issue_exp(4'h8, 4'h8, 4'h2, "R8");
      issue_exp(4'h8, 4'h2, 4'hF, "R8");

      // R7: random pairs separated by idle clocks carrying junk operands
      for (int k = 0; k < 40; k++) begin
         issue(M'($urandom), M'($urandom), "R7");
         for (int g = 0; g < int'($urandom_range(0, 3)); g++) bubble();
      end

      // R4: reset in mid-stream discards in-flight pairs
      for (int k = 0; k < 5; k++) issue(M'($urandom), M'($urandom), "R1");
      @(negedge clk);
      rst = 1'b1;
      valid_in = 1'b0;
      sb_q.delete();
      @(posedge clk);
      #5;
      check(valid_out == 1'b0, "R4", "valid_out after mid reset", int'(valid_out), 0);
      check(prod_out == '0, "R4", "prod_out after mid reset", int'(prod_out), 0);
      @(negedge clk);
      rst = 1'b0;
      repeat (LAT + 2) bubble();

      // R1: stream resumes correctly after reset
      for (int k = 0; k < 10; k++) issue(M'($urandom), M'($urandom), "R1");
      repeat (LAT + 4) bubble();

      check(sb_q.size() == 0, "R3", "pending results at end", sb_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule